// File: doc/BRIEF.md
# Machine-Mode CSR Subset with Write Legalization

This block holds a group of machine-level control and status registers for a small RISC-V core and applies the privileged-spec rules for what software may store in them. Several of the registers are hard-wired. A write to a field that is not implemented is dropped without any error. A privilege code that the core does not support is turned into User mode, not Machine mode. The block also stores the machine cycle and retired-instruction counters as 64-bit values, and software writes each one through two 32-bit halves. The counters do not increment inside this block. That logic belongs to the pipeline.

The core drives a 12-bit CSR address, 32-bit write data, a write enable and a read enable. Read data and an illegal-access flag come back combinationally in the same cycle. A write becomes visible on the next clock edge. Two parameters shape the block: the value that the configuration-pointer register returns, and the number of implemented hardware performance counters. The performance counters start at index 3.

Top module: `mcsr_subset`

## Requirements
- R1: The status-high register (0x310) and the two environment-configuration halves (0x30A, 0x31A) return 0 on every read. Writes to them have no effect and raise no illegal flag.
- R2: The configuration pointer (0xF15) reads as parameter `CFGPTR_VALUE`. Any address whose bits [11:10] are 2'b11 is read-only. A write to such an address raises `csr_illegal` and changes no state.
- R3: In the counter-inhibit register (0x320), bits 0, 2 and 3 to 3+`NUM_HPM`-1 can be written. Bit 1 and every bit at or above 3+`NUM_HPM` always read 0.
- R4: The event selector at 0x320+k reads as 1<<(k-3) when 3 ≤ k < 3+`NUM_HPM`, and as 0 for larger k up to 31. Writes to any event selector are ignored. Addresses 0x321 and 0x322 are unimplemented.
- R5: `mstatus` (0x300) stores MIE at bit 3, MPIE at bit 7, MPP at bits [12:11] and MPRV at bit 17. Every other bit reads 0.
- R6: When MPP is written with 2'b01 or 2'b10, it stores 2'b00 (User). When written with 2'b11 (Machine) or 2'b00, it stores the written value.
- R7: `dcsr` (0x7B0) stores PRV at bits [1:0], step at bit 2 and ebreakm at bit 15. Bits [31:28] always read 4. PRV follows the same rule as R6.
- R8: The cycle counter (0xB00 low, 0xB80 high) and the instret counter (0xB02 low, 0xB82 high) are 64 bits wide. A write to one half leaves the other half unchanged.
- R9: A read or write of any other address raises `csr_illegal`, returns 0 and changes no state.
- R10: A write takes effect on the next clock edge. A read in the same cycle as a write returns the old value. With `csr_re` low, `csr_rdata` is 0, and with both enables low, `csr_illegal` is 0.
- R11: After reset, `mstatus` reads 0, `dcsr` reads 0x4000_0003 (PRV = Machine), and the inhibit register and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| csr_we | input | 1 | Write enable |
| csr_re | input | 1 | Read enable |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Access to an unimplemented address, or a write to a read-only address |

## Verification
The bench first writes all ones to each writable register. This shows which bits are stored and which are masked. It then writes the codes 2'b01 and 2'b10 into MPP and PRV, which separates fallback to User from fallback to Machine or from keeping the raw code. Writes to a single counter half, each followed by reads of both halves, show that the halves are independent. Reads issued in the same cycle as a write show whether the write is registered or passed straight through. Accesses to unimplemented and read-only addresses, each followed by reads of real registers, show that such accesses are rejected and leave no side effects.

// File: rtl/mcsr_pkg.sv
// Shared addresses, field types and legalization helper for the CSR subset.
// Assumes a 32-bit machine with only Machine and User privilege modes.
package mcsr_pkg;

    localparam logic [11:0] A_MSTATUS   = 12'h300;
    localparam logic [11:0] A_MENVCFG   = 12'h30A;
    localparam logic [11:0] A_MSTATUSH  = 12'h310;
    localparam logic [11:0] A_MENVCFGH  = 12'h31A;
    localparam logic [11:0] A_MCNTINH   = 12'h320;
    localparam logic [11:0] A_DCSR      = 12'h7B0;
    localparam logic [11:0] A_MCYCLE    = 12'hB00;
    localparam logic [11:0] A_MINSTRET  = 12'hB02;
    localparam logic [11:0] A_MCYCLEH   = 12'hB80;
    localparam logic [11:0] A_MINSTRETH = 12'hB82;
    localparam logic [11:0] A_MCFGPTR   = 12'hF15;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_M = 2'b11;

    // Fixed debug-spec version reported in dcsr[31:28]
    localparam logic [3:0] DBG_VERSION = 4'd4;

    typedef struct packed {
        logic       mprv;
        logic [1:0] mpp;
        logic       mpie;
        logic       mie;
    } mstatus_f_t;

    typedef struct packed {
        logic       ebreakm;
        logic       step;
        logic [1:0] prv;
    } dcsr_f_t;

    typedef struct packed {
        logic mstatus;
        logic dcsr;
        logic zero_reg;
        logic cfgptr;
        logic inhibit;
        logic hpmev;
        logic cyc_lo;
        logic cyc_hi;
        logic ins_lo;
        logic ins_hi;
    } csr_sel_t;

    // Map an unsupported privilege code onto User mode
    function automatic logic [1:0] legal_priv(input logic [1:0] p);
        return (p == PRIV_M) ? PRIV_M : PRIV_U;
    endfunction

endpackage

// File: rtl/mcsr_decode.sv
// Address decoder: turns a CSR address into one-hot register selects.
// Assumes the event-selector window is 0x323..0x33F and that addresses
// with bits [11:10] == 2'b11 are read-only.
module mcsr_decode
    import mcsr_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_t    sel,
    output logic [4:0]  ev_idx,
    output logic        known,
    output logic        read_only
);

    // One-hot select for the addressed register
    always_comb begin
        sel = '0;
        case (addr)
            A_MSTATUS:                        sel.mstatus  = 1'b1;
            A_MSTATUSH, A_MENVCFG, A_MENVCFGH: sel.zero_reg = 1'b1;
            A_MCFGPTR:                        sel.cfgptr   = 1'b1;
            A_MCNTINH:                        sel.inhibit  = 1'b1;
            A_DCSR:                           sel.dcsr     = 1'b1;
            A_MCYCLE:                         sel.cyc_lo   = 1'b1;
            A_MCYCLEH:                        sel.cyc_hi   = 1'b1;
            A_MINSTRET:                       sel.ins_lo   = 1'b1;
            A_MINSTRETH:                      sel.ins_hi   = 1'b1;
            default: sel.hpmev = (addr[11:5] == A_MCNTINH[11:5]) && (addr[4:0] >= 5'd3);
        endcase
    end

    assign ev_idx    = addr[4:0];
    assign known     = |sel;
    assign read_only = (addr[11:10] == 2'b11);

endmodule

// File: rtl/mcsr_status_regs.sv
// Storage for the implemented mstatus and dcsr fields, with privilege
// legalization on write. Assumes callers gate the write strobes.
module mcsr_status_regs
    import mcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_we,
    input  mstatus_f_t ms_wr,
    input  logic       dc_we,
    input  dcsr_f_t    dc_wr,
    output mstatus_f_t ms_q,
    output dcsr_f_t    dc_q
);

    // mstatus fields: reset to all zero (MPP = User)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else if (ms_we) begin
            ms_q.mprv <= ms_wr.mprv;
            ms_q.mpp  <= legal_priv(ms_wr.mpp);
            ms_q.mpie <= ms_wr.mpie;
            ms_q.mie  <= ms_wr.mie;
        end
    end

    // dcsr fields: reset with PRV = Machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_q.ebreakm <= 1'b0;
            dc_q.step    <= 1'b0;
            dc_q.prv     <= PRIV_M;
        end else if (dc_we) begin
            dc_q.ebreakm <= dc_wr.ebreakm;
            dc_q.step    <= dc_wr.step;
            dc_q.prv     <= legal_priv(dc_wr.prv);
        end
    end

endmodule

// File: rtl/mcsr_counter_regs.sv
// Counter-inhibit mask and the 64-bit cycle/instret counters, written by
// 32-bit halves. Assumes 0 <= NUM_HPM <= 29; no increment logic here.
module mcsr_counter_regs #(
    parameter int NUM_HPM = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] wdata,
    input  logic        inh_we,
    input  logic [1:0]  lo_we,
    input  logic [1:0]  hi_we,
    output logic [31:0] inhibit_q,
    output logic [63:0] cnt_q [2]
);

    localparam int          IMPL_TOP = 3 + NUM_HPM;
    localparam logic [63:0] LOW_ONES = (64'd1 << IMPL_TOP) - 64'd1;
    localparam logic [31:0] INH_MASK = LOW_ONES[31:0] & ~32'h2;

    // Inhibit register keeps only the implemented counter bits
    always_ff @(posedge clk) begin
        if (!rst_n) inhibit_q <= '0;
        else if (inh_we) inhibit_q <= wdata & INH_MASK;
    end

    // Counter 0 = cycle, counter 1 = instret; each half written on its own
    for (genvar c = 0; c < 2; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[c] <= '0;
            end else begin
                if (lo_we[c]) cnt_q[c][31:0]  <= wdata;
                if (hi_we[c]) cnt_q[c][63:32] <= wdata;
            end
        end
    end

endmodule

// File: rtl/mcsr_subset.sv
// Machine-mode CSR subset: decodes an access, gates writes, legalizes
// fields and muxes read data. Reads are combinational; writes land on the
// next clock edge. Assumes 0 <= NUM_HPM <= 29.
module mcsr_subset
    import mcsr_pkg::*;
#(
    parameter logic [31:0] CFGPTR_VALUE = 32'h0,
    parameter int          NUM_HPM      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    input  logic        csr_we,
    input  logic        csr_re,
    output logic [31:0] csr_rdata,
    output logic        csr_illegal
);

    localparam int EV_SLOTS = 32;

    csr_sel_t    sel;
    logic [4:0]  ev_idx;
    logic        known;
    logic        read_only;
    logic        wr_ok;
    mstatus_f_t  ms_q;
    dcsr_f_t     dc_q;
    logic [31:0] inhibit_q;
    logic [63:0] cnt_q [2];
    logic [31:0] ev_tab [EV_SLOTS];
    logic [31:0] rd_word;

    mcsr_decode u_dec (
        .addr      (csr_addr),
        .sel       (sel),
        .ev_idx    (ev_idx),
        .known     (known),
        .read_only (read_only)
    );

    // A write is committed only to an implemented, writable address
    assign wr_ok       = csr_we && known && !read_only;
    assign csr_illegal = (csr_we || csr_re) && (!known || (csr_we && read_only));

    mcsr_status_regs u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .ms_we (wr_ok && sel.mstatus),
        .ms_wr ({csr_wdata[17], csr_wdata[12:11], csr_wdata[7], csr_wdata[3]}),
        .dc_we (wr_ok && sel.dcsr),
        .dc_wr ({csr_wdata[15], csr_wdata[2], csr_wdata[1:0]}),
        .ms_q  (ms_q),
        .dc_q  (dc_q)
    );

    mcsr_counter_regs #(.NUM_HPM(NUM_HPM)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata     (csr_wdata),
        .inh_we    (wr_ok && sel.inhibit),
        .lo_we     ({wr_ok && sel.ins_lo, wr_ok && sel.cyc_lo}),
        .hi_we     ({wr_ok && sel.ins_hi, wr_ok && sel.cyc_hi}),
        .inhibit_q (inhibit_q),
        .cnt_q     (cnt_q)
    );

    // Hard-wired event selector values: one-hot for implemented indices
    for (genvar k = 0; k < EV_SLOTS; k++) begin : g_ev
        if (k >= 3 && k < 3 + NUM_HPM) begin : g_on
            assign ev_tab[k] = 32'd1 << (k - 3);
        end else begin : g_off
            assign ev_tab[k] = '0;
        end
    end

    // Read mux over the selected register
    always_comb begin
        rd_word = '0;
        if (sel.mstatus)
            rd_word = {14'b0, ms_q.mprv, 4'b0, ms_q.mpp, 3'b0, ms_q.mpie, 3'b0, ms_q.mie, 3'b0};
        if (sel.dcsr)
            rd_word = {DBG_VERSION, 12'b0, dc_q.ebreakm, 12'b0, dc_q.step, dc_q.prv};
        if (sel.cfgptr)  rd_word = CFGPTR_VALUE;
        if (sel.inhibit) rd_word = inhibit_q;
        if (sel.hpmev)   rd_word = ev_tab[ev_idx];
        if (sel.cyc_lo)  rd_word = cnt_q[0][31:0];
        if (sel.cyc_hi)  rd_word = cnt_q[0][63:32];
        if (sel.ins_lo)  rd_word = cnt_q[1][31:0];
        if (sel.ins_hi)  rd_word = cnt_q[1][63:32];
    end

    assign csr_rdata = csr_re ? rd_word : '0;

endmodule

// File: rtl/mcsr_subset_chk.sv
// Port-level property checker for mcsr_subset, attached by bind.
module mcsr_subset_chk
    import mcsr_pkg::*;
#(
    parameter logic [31:0] CFGPTR_VALUE = 32'h0,
    parameter int          NUM_HPM      = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] csr_addr,
    input logic [31:0] csr_wdata,
    input logic        csr_we,
    input logic        csr_re,
    input logic [31:0] csr_rdata,
    input logic        csr_illegal
);

    localparam logic [63:0] LOW_ONES  = (64'd1 << (3 + NUM_HPM)) - 64'd1;
    localparam logic [31:0] IMPL_MASK = LOW_ONES[31:0] & ~32'h2;

    // R1: hard-wired zero registers
    a_r1_zero_regs: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && (csr_addr == A_MSTATUSH || csr_addr == A_MENVCFG || csr_addr == A_MENVCFGH)
        |-> csr_rdata == 32'h0 && !csr_illegal);

    // R2: read-only pointer value and rejected writes
    a_r2_cfgptr_val: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && csr_addr == A_MCFGPTR |-> csr_rdata == CFGPTR_VALUE);
    a_r2_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we && csr_addr[11:10] == 2'b11 |-> csr_illegal);

    // R3: unimplemented inhibit bits stay zero
    a_r3_inh_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && csr_addr == A_MCNTINH |-> (csr_rdata & ~IMPL_MASK) == 32'h0);

    // R4: event selectors are at most one-hot
    a_r4_ev_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && csr_addr[11:5] == A_MCNTINH[11:5] && csr_addr[4:0] >= 5'd3
        |-> $countones(csr_rdata) <= 1);

    // R6: MPP never holds an unsupported code
    a_r6_mpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && csr_addr == A_MSTATUS |-> csr_rdata[12:11] == 2'b00 || csr_rdata[12:11] == 2'b11);

    // R7: PRV legal and version constant
    a_r7_dcsr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && csr_addr == A_DCSR
        |-> (csr_rdata[1:0] == 2'b00 || csr_rdata[1:0] == 2'b11) && csr_rdata[31:28] == 4'd4);

    // R9: rejected reads return zero
    a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && !csr_we && csr_illegal |-> csr_rdata == 32'h0);

    // R10: idle cycles are quiet
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_re && !csr_we |-> csr_rdata == 32'h0 && !csr_illegal);

    // R10: a cycle-low write is visible on the next cycle
    a_r10_write_next: assert property (@(posedge clk) disable iff (!rst_n)
        csr_re && csr_addr == A_MCYCLE && $past(rst_n) && $past(csr_we && csr_addr == A_MCYCLE)
        |-> csr_rdata == $past(csr_wdata));

endmodule

bind mcsr_subset mcsr_subset_chk #(
    .CFGPTR_VALUE (CFGPTR_VALUE),
    .NUM_HPM      (NUM_HPM)
) u_chk (.*);

// File: tb/sim_mcsr_subset.sv
`timescale 1ns/1ps
module sim_mcsr_subset;

    localparam logic [31:0] CFG = 32'h0000_1000;
    localparam int          NH  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_we = 1'b0;
    logic        csr_re = 1'b0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // Behavioural model state
    logic [31:0] m_status, m_dcsr, m_inh;
    logic [63:0] m_cyc, m_ins;

    always #5 clk = ~clk;

    mcsr_subset #(.CFGPTR_VALUE(CFG), .NUM_HPM(NH)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_re(csr_re), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
    );

    function automatic logic [1:0] fix_priv(input logic [1:0] p);
        return (p == 2'b11) ? 2'b11 : 2'b00;
    endfunction

    // Expected {known, data} for an address from the model state
    function automatic logic [32:0] lookup(input logic [11:0] a);
        int idx;
        case (a)
            12'h300: return {1'b1, m_status};
            12'h310, 12'h30A, 12'h31A: return {1'b1, 32'h0};
            12'hF15: return {1'b1, CFG};
            12'h320: return {1'b1, m_inh};
            12'h7B0: return {1'b1, m_dcsr | 32'h4000_0000};
            12'hB00: return {1'b1, m_cyc[31:0]};
            12'hB80: return {1'b1, m_cyc[63:32]};
            12'hB02: return {1'b1, m_ins[31:0]};
            12'hB82: return {1'b1, m_ins[63:32]};
            default: begin
                if (a >= 12'h323 && a <= 12'h33F) begin
                    idx = int'(a) - 'h320;
                    return {1'b1, (idx < 3 + NH) ? (32'd1 << (idx - 3)) : 32'h0};
                end
                return {1'b0, 32'h0};
            end
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] w);
        logic [31:0] mask;
        mask = 32'h0;
        for (int i = 0; i < 3 + NH; i++) if (i != 1) mask[i] = 1'b1;
        case (a)
            12'h300: m_status = (w & 32'h0002_0088) | ({30'b0, fix_priv(w[12:11])} << 11);
            12'h7B0: m_dcsr = (w & 32'h0000_8004) | {30'b0, fix_priv(w[1:0])};
            12'h320: m_inh = w & mask;
            12'hB00: m_cyc[31:0] = w;
            12'hB80: m_cyc[63:32] = w;
            12'hB02: m_ins[31:0] = w;
            12'hB82: m_ins[63:32] = w;
            default: ;
        endcase
    endtask

    // One clock of stimulus, compared against the model before the edge
    task automatic access(input string req, input logic [11:0] a, input logic [31:0] w,
                          input logic we, input logic re);
        logic [32:0] look;
        logic        exp_ill;
        logic [31:0] exp_d;
        @(negedge clk);
        csr_addr = a; csr_wdata = w; csr_we = we; csr_re = re;
        #1;
        look    = lookup(a);
        exp_ill = (we || re) && (!look[32] || (we && a[11:10] == 2'b11));
        exp_d   = (re && look[32]) ? look[31:0] : 32'h0;
        vectors++;
        if (csr_rdata !== exp_d || csr_illegal !== exp_ill) begin
            fails++;
            $display("FAIL %s addr=%h: rdata=%h illegal=%b, expected rdata=%h illegal=%b",
                     req, a, csr_rdata, csr_illegal, exp_d, exp_ill);
        end
        if (we && look[32] && a[11:10] != 2'b11) model_write(a, w);
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        access(req, a, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic wr(input string req, input logic [11:0] a, input logic [31:0] w);
        access(req, a, w, 1'b1, 1'b0);
    endtask

    initial begin
        m_status = 0; m_dcsr = 32'h3; m_inh = 0; m_cyc = 0; m_ins = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        rd("R11", 12'h300); rd("R11", 12'h7B0); rd("R11", 12'h320);
        rd("R11", 12'hB00); rd("R11", 12'hB82);

        // R1 hard-wired zero registers
        wr("R1", 12'h310, 32'hFFFF_FFFF); rd("R1", 12'h310);
        wr("R1", 12'h30A, 32'hFFFF_FFFF); rd("R1", 12'h30A);
        wr("R1", 12'h31A, 32'hA5A5_A5A5); rd("R1", 12'h31A);

        // R2 read-only pointer
        rd("R2", 12'hF15); wr("R2", 12'hF15, 32'hFFFF_FFFF); rd("R2", 12'hF15);
        access("R2", 12'hF15, 32'h1234_5678, 1'b1, 1'b1);

        // R3 inhibit mask
        wr("R3", 12'h320, 32'hFFFF_FFFF); rd("R3", 12'h320);
        wr("R3", 12'h320, 32'h0000_0012); rd("R3", 12'h320);

        // R4 event selectors
        rd("R4", 12'h323); rd("R4", 12'h324); rd("R4", 12'h326);
        rd("R4", 12'h327); rd("R4", 12'h33F);
        wr("R4", 12'h323, 32'hFFFF_FFFF); rd("R4", 12'h323);
        rd("R4", 12'h321); wr("R4", 12'h322, 32'h1); rd("R4", 12'h320);

        // R5 / R6 mstatus fields and MPP legalization
        wr("R5", 12'h300, 32'hFFFF_FFFF); rd("R5", 12'h300);
        wr("R6", 12'h300, 32'h0000_0800); rd("R6", 12'h300);
        wr("R6", 12'h300, 32'h0000_1000); rd("R6", 12'h300);
        wr("R6", 12'h300, 32'h0000_1808); rd("R6", 12'h300);
        wr("R6", 12'h300, 32'h0000_0080); rd("R6", 12'h300);

        // R7 dcsr fields and PRV legalization
        wr("R7", 12'h7B0, 32'hFFFF_FFFF); rd("R7", 12'h7B0);
        wr("R7", 12'h7B0, 32'h0000_0001); rd("R7", 12'h7B0);
        wr("R7", 12'h7B0, 32'h0000_8006); rd("R7", 12'h7B0);

        // R8 counter halves
        wr("R8", 12'hB00, 32'hDEAD_BEEF); rd("R8", 12'hB00); rd("R8", 12'hB80);
        wr("R8", 12'hB80, 32'h1234_5678); rd("R8", 12'hB00); rd("R8", 12'hB80);
        wr("R8", 12'hB82, 32'hCAFE_0001); rd("R8", 12'hB02); rd("R8", 12'hB82);
        wr("R8", 12'hB02, 32'h0000_00FF); rd("R8", 12'hB02); rd("R8", 12'hB82);
        rd("R8", 12'hB00);

        // R9 unimplemented addresses leave state untouched
        rd("R9", 12'h7C0); wr("R9", 12'h305, 32'hFFFF_FFFF);
        access("R9", 12'h301, 32'hFFFF_FFFF, 1'b1, 1'b1);
        rd("R9", 12'h300); rd("R9", 12'h305);

        // R10 timing: same-cycle read sees old value, idle is quiet
        access("R10", 12'hB00, 32'h0BAD_F00D, 1'b1, 1'b1);
        rd("R10", 12'hB00);
        access("R10", 12'h300, 32'h0, 1'b0, 1'b0);
        access("R10", 12'h7C0, 32'h0, 1'b0, 1'b0);
        access("R10", 12'h7B0, 32'h0000_0003, 1'b1, 1'b1);
        rd("R10", 12'h7B0);

        @(negedge clk);
        csr_we = 1'b0; csr_re = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule